// File: doc/BRIEF.md
# Tray Hit Multiplicity Summer

This block reduces the discriminated hit lines of one detector tray to a small count for the first-level trigger. The 192 channels fall into 24 groups of 8. Each group is ORed into one group-hit bit, and a group bit counts once however many of its channels fire. The group bits that are not masked off are added into a 5-bit multiplicity between 0 and 24.

The multiplicity is formed by combinational logic only. No clock lies in the path from the channel lines to the sum output, so the trigger electronics can sample the sum on their own strobe at any moment. This keeps the latency to a few gate delays, far inside a budget of several hundred nanoseconds, and it supports sampling rates near 10 MHz.

A clocked side-path handles configuration and readout. A 24-bit mask register removes noisy groups from the sum. A holding register captures the current sum on a synchronous trigger strobe and shows it with a valid flag.

Top module: `trig_mult_sum`

## Requirements
- R1: `mult_now` is a 5-bit unsigned value that never exceeds 24. With all 24 groups hit and none masked, it equals 24.
- R2: Group g owns channels `chan_hit[8g+7:8g]`. An unmasked group adds exactly one to the sum when at least one of its eight channels is 1, and adds nothing when all eight are 0.
- R3: `mult_now` is a combinational function of `chan_hit` and the mask register. It follows a change of `chan_hit` with no clock edge in between.
- R4: Mask bit g set to 1 removes group g from the sum. When `mask_load` is 1 at a rising clock edge, the mask register takes `mask_data` at that edge. Until then the previous mask stays in force.
- R5: When `trig_strobe` is 1 at a rising clock edge, `mult_held` takes the value `mult_now` had just before that edge.
- R6: When `trig_strobe` is 0 at a rising edge, `mult_held` keeps its value.
- R7: `held_valid` goes to 1 at the first edge that has `trig_strobe` set. It then stays 1 until reset.
- R8: While `rst_n` is low, `mult_held` is 0, `held_valid` is 0 and the mask is all zeros, so every group is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mask and capture registers only |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_hit | input | 192 | Discriminator outputs; channel 8g+k belongs to group g |
| mask_load | input | 1 | Write enable for the group mask |
| mask_data | input | 24 | New mask; bit g = 1 excludes group g |
| trig_strobe | input | 1 | Synchronous trigger strobe that captures the sum |
| mult_now | output | 5 | Live asynchronous multiplicity, 0 to 24 |
| mult_held | output | 5 | Sum captured at the last strobe |
| held_valid | output | 1 | Set once a capture has happened |

## Verification
A fault in the OR or adder logic shows on `mult_now` in the same cycle as the input pattern that exposes it. A stuck or wrongly placed mask bit shows as soon as that group changes its hit state. A capture or valid fault shows on `mult_held` or `held_valid` one edge after a strobe. A hold fault shows at the first edge without a strobe after the sum has moved. The reference model is checked against the design every cycle, so each of these faults is caught within a cycle of the stimulus that exposes it.

// File: rtl/mult_pkg.sv
package mult_pkg;
   // Choice of adder structure for the group-bit reduction.
   typedef enum logic {
      ADD_CHAIN = 1'b0,
      ADD_TREE  = 1'b1
   } add_style_e;

   // Width needed for a count ranging 0..n.
   function automatic int count_width(input int n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/mult_group_or.sv
module mult_group_or #(
   parameter int NUM_GROUPS = 24,
   parameter int GROUP_W    = 8
) (
   input  logic [NUM_GROUPS*GROUP_W-1:0] chan_in,
   input  logic [NUM_GROUPS-1:0]         group_off,
   output logic [NUM_GROUPS-1:0]         group_bit
);
   // One OR reduction per group, gated by that group's mask bit.
   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      assign group_bit[g] = (|chan_in[g*GROUP_W +: GROUP_W]) & ~group_off[g];
   end
endmodule

// File: rtl/mult_popcount.sv
module mult_popcount
   import mult_pkg::*;
#(
   parameter int         NUM_BITS = 24,
   parameter int         SUM_W    = 5,
   parameter add_style_e STYLE    = ADD_TREE
) (
   input  logic [NUM_BITS-1:0] bits_in,
   output logic [SUM_W-1:0]    count
);
   if (STYLE == ADD_TREE) begin : g_tree
      localparam int LEVELS = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1;
      localparam int PAD    = 1 << LEVELS;
      logic [SUM_W-1:0] acc [PAD];

      // Pairwise reduction; each pass halves the live operand count.
      always_comb begin
         for (int i = 0; i < PAD; i++) begin
            if (i < NUM_BITS) acc[i] = SUM_W'(bits_in[i]);
            else              acc[i] = '0;
         end
         for (int w = PAD / 2; w >= 1; w = w / 2) begin
            for (int i = 0; i < w; i++) begin
               acc[i] = acc[2*i] + acc[2*i+1];
            end
         end
      end
      assign count = acc[0];
   end else begin : g_chain
      logic [SUM_W-1:0] run;

      // Linear accumulation: least area, deepest path.
      always_comb begin
         run = '0;
         for (int i = 0; i < NUM_BITS; i++) begin
            run = run + SUM_W'(bits_in[i]);
         end
      end
      assign count = run;
   end
endmodule

// File: rtl/mult_capture.sv
module mult_capture #(
   parameter int SUM_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe,
   input  logic [SUM_W-1:0] sum_in,
   output logic [SUM_W-1:0] held,
   output logic             valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held  <= '0;
         valid <= 1'b0;
      end else if (strobe) begin
         held  <= sum_in;
         valid <= 1'b1;
      end
   end
endmodule

// File: rtl/trig_mult_sum.sv
module trig_mult_sum
   import mult_pkg::*;
#(
   parameter int         NUM_GROUPS = 24,
   parameter int         GROUP_W    = 8,
   parameter add_style_e ADD_STYLE  = ADD_TREE,
   localparam int        NUM_CHAN   = NUM_GROUPS * GROUP_W,
   localparam int        SUM_W      = count_width(NUM_GROUPS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_CHAN-1:0]   chan_hit,
   input  logic                  mask_load,
   input  logic [NUM_GROUPS-1:0] mask_data,
   input  logic                  trig_strobe,
   output logic [SUM_W-1:0]      mult_now,
   output logic [SUM_W-1:0]      mult_held,
   output logic                  held_valid
);
   // Elaboration-time parameter checks.
   if (NUM_GROUPS < 2) begin : g_bad_groups
      $error("trig_mult_sum: NUM_GROUPS must be at least 2");
   end
   if (GROUP_W < 1) begin : g_bad_width
      $error("trig_mult_sum: GROUP_W must be at least 1");
   end

   logic [NUM_GROUPS-1:0] group_mask;
   logic [NUM_GROUPS-1:0] group_bit;

   // Mask register: 1 excludes a group, reset enables all groups.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         group_mask <= '0;
      else if (mask_load) group_mask <= mask_data;
   end

   mult_group_or #(
      .NUM_GROUPS (NUM_GROUPS),
      .GROUP_W    (GROUP_W)
   ) or_i (
      .chan_in   (chan_hit),
      .group_off (group_mask),
      .group_bit (group_bit)
   );

   mult_popcount #(
      .NUM_BITS (NUM_GROUPS),
      .SUM_W    (SUM_W),
      .STYLE    (ADD_STYLE)
   ) pop_i (
      .bits_in (group_bit),
      .count   (mult_now)
   );

   mult_capture #(
      .SUM_W (SUM_W)
   ) cap_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (trig_strobe),
      .sum_in (mult_now),
      .held   (mult_held),
      .valid  (held_valid)
   );
endmodule

// File: rtl/trig_mult_sum_chk.sv
module trig_mult_sum_chk #(
   parameter int NUM_GROUPS = 24,
   parameter int NUM_CHAN   = 192,
   parameter int SUM_W      = 5
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NUM_CHAN-1:0]   chan_hit,
   input logic                  mask_load,
   input logic [NUM_GROUPS-1:0] mask_data,
   input logic                  trig_strobe,
   input logic [SUM_W-1:0]      mult_now,
   input logic [SUM_W-1:0]      mult_held,
   input logic                  held_valid
);
   p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      32'(mult_now) <= NUM_GROUPS);

   p_quiet_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_hit == '0) |-> (mult_now == '0));

   p_full_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_load && (&mask_data)) |=> (mult_now == '0));

   p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      trig_strobe |=> (mult_held == $past(mult_now)));

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_strobe |=> $stable(mult_held));

   p_valid_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trig_strobe |=> held_valid);

   p_valid_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      held_valid |=> held_valid);

   p_held_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      32'(mult_held) <= NUM_GROUPS);
endmodule

bind trig_mult_sum trig_mult_sum_chk #(
   .NUM_GROUPS (NUM_GROUPS),
   .NUM_CHAN   (NUM_CHAN),
   .SUM_W      (SUM_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .chan_hit    (chan_hit),
   .mask_load   (mask_load),
   .mask_data   (mask_data),
   .trig_strobe (trig_strobe),
   .mult_now    (mult_now),
   .mult_held   (mult_held),
   .held_valid  (held_valid)
);

// File: tb/trig_mult_sum_tb_top.sv
`timescale 1ns/1ps
module trig_mult_sum_tb_top;
   localparam int NG = 24;
   localparam int GW = 8;
   localparam int NC = NG * GW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NC-1:0] chan_hit = '0;
   logic          mask_load = 1'b0;
   logic [NG-1:0] mask_data = '0;
   logic          trig_strobe = 1'b0;
   logic [4:0]    mult_now;
   logic [4:0]    mult_held;
   logic          held_valid;

   int compared = 0;
   int mismatched = 0;

   // Reference state kept by the bench.
   logic [NG-1:0] m_mask = '0;
   int            m_held = 0;
   int            m_valid = 0;

   always #10 clk = ~clk;

   trig_mult_sum dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .chan_hit    (chan_hit),
      .mask_load   (mask_load),
      .mask_data   (mask_data),
      .trig_strobe (trig_strobe),
      .mult_now    (mult_now),
      .mult_held   (mult_held),
      .held_valid  (held_valid)
   );

   function automatic int ref_sum(input logic [NC-1:0] c, input logic [NG-1:0] m);
      int n = 0;
      for (int g = 0; g < NG; g++) begin
         int any = 0;
         for (int k = 0; k < GW; k++) if (c[g*GW+k]) any = 1;
         if (any == 1 && !m[g]) n++;
      end
      return n;
   endfunction

   function automatic logic [NC-1:0] rand_hits(input int density);
      logic [NC-1:0] v;
      for (int w = 0; w < NC / 32; w++) begin
         logic [31:0] r = $urandom;
         for (int d = 0; d < density; d++) r = r & $urandom;
         v[w*32 +: 32] = r;
      end
      return v;
   endfunction

   task automatic check(input int act, input int exp, input string tag);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cycle(input logic [NC-1:0] c, input logic ld, input logic [NG-1:0] md,
                        input logic stb, input string tag);
      int s;
      @(negedge clk);
      check(int'(mult_held), m_held, "R5/R6 held value");
      check(int'(held_valid), m_valid, "R7 valid flag");
      chan_hit = c; mask_load = ld; mask_data = md; trig_strobe = stb;
      #1;
      // R3: live sum must already follow the new channels, old mask in force (R4)
      s = ref_sum(c, m_mask);
      check(int'(mult_now), s, tag);
      check(int'(mult_now <= 5'd24), 1, "R1 range");
      @(posedge clk);
      if (stb) begin m_held = s; m_valid = 1; end
      if (ld) m_mask = md;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog R3: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      logic [NC-1:0] pat;
      repeat (3) @(negedge clk);
      // R8: reset state
      check(int'(mult_held), 0, "R8 held in reset");
      check(int'(held_valid), 0, "R8 valid in reset");
      check(int'(mult_now), 0, "R8 sum idle in reset");
      rst_n = 1'b1;

      // R1/R8: mask reset to zero, all groups count
      cycle('1, 1'b0, '0, 1'b0, "R1 all hit gives 24");
      cycle('0, 1'b0, '0, 1'b0, "R2 no hit gives 0");
      cycle('1, 1'b0, '0, 1'b1, "R5 capture full");
      cycle('0, 1'b0, '0, 1'b0, "R6 hold after capture");

      // R2: exactly one channel per group, each position
      for (int k = 0; k < GW; k++) begin
         pat = '0;
         for (int g = 0; g < NG; g++) pat[g*GW+k] = 1'b1;
         cycle(pat, 1'b0, '0, k[0], "R2 one channel per group");
      end

      // R2: one group with several channels
      for (int g = 0; g < NG; g++) begin
         pat = '0;
         pat[g*GW +: GW] = 8'($urandom_range(1, 255));
         cycle(pat, 1'b0, '0, 1'b0, "R2 single group");
      end

      // R3/R5/R6: sparse random with random strobes
      for (int i = 0; i < 150; i++)
         cycle(rand_hits(3), 1'b0, '0, ($urandom_range(0, 3) == 0), "R3 sparse random");

      // R4: random masks on random hits
      for (int i = 0; i < 150; i++)
         cycle(rand_hits($urandom_range(1, 4)), ($urandom_range(0, 4) == 0), NG'($urandom),
               ($urandom_range(0, 2) == 0), "R4 masked random");

      // R4: everything masked
      cycle('1, 1'b1, '1, 1'b0, "R4 load full mask");
      cycle('1, 1'b0, '0, 1'b1, "R4 full mask gives 0");
      cycle(rand_hits(0), 1'b0, '0, 1'b0, "R4 full mask dense");
      // R4: clear mask, one group left masked
      cycle('1, 1'b1, 24'h000001, 1'b0, "R4 mask change timing");
      cycle('1, 1'b0, '0, 1'b1, "R4 one group masked gives 23");

      // dense random, unmasked
      cycle('0, 1'b1, '0, 1'b0, "R4 unmask");
      for (int i = 0; i < 100; i++)
         cycle(rand_hits(0), 1'b0, '0, ($urandom_range(0, 1) == 0), "R1 dense random");
      cycle('0, 1'b0, '0, 1'b0, "R6 final hold");
      @(negedge clk);
      check(int'(mult_held), m_held, "R6 final held");
      check(int'(held_valid), 1, "R7 valid stays set");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule